// File: doc/BRIEF.md
# DSP Register File with Guard-Bit Accumulators

This block holds the operand and result registers of a fixed-point DSP datapath. There are eight data registers: two 40-bit accumulators, each a 32-bit body plus an 8-bit guard field in bits 39..32, and six plain 32-bit registers. A separate 32-bit status/control word sits beside them. The arithmetic unit reads two sources and writes one result per cycle, always as 40-bit quantities. The file widens 32-bit registers on the way out by sign extension and narrows results on the way in by dropping the top eight bits. Accumulators pass all 40 bits in both directions.

Two 16-bit memory ports, one for the X side and one for the Y side, load and store the upper halfword of a register. Each side may load only into its own pair of registers, and a request for any other target is refused with a one-cycle error pulse. A 32-bit system-register port gives the general-register side access to the first accumulator, the four X/Y registers and the status word.

Top module: `dsp_guard_regfile`

## Requirements
- R1: After reset every data register, both guard fields and the status word are zero, and both load error flags are low.
- R2: The register index is 3 bits: 0 = A0, 1 = A1, 2 = X0, 3 = X1, 4 = Y0, 5 = Y1, 6 = M0, 7 = M1. Both source read ports are combinational, and a write becomes visible after the rising edge that samples it.
- R3: Reading index 0 or 1 on a source port returns the full 40 bits, including guard bits 39..32.
- R4: Reading index 2..7 on a source port returns the 32-bit value with bit 31 copied into bits 39..32.
- R5: A DSP write to index 0 or 1 stores all 40 bits. A DSP write to index 2..7 stores bits 31..0 and discards bits 39..32. With the DSP write enable low, no register changes.
- R6: A legal memory load writes the 16-bit data into bits 31..16 of the target and clears bits 15..0. Each store port returns bits 31..16 of the register its index selects.
- R7: An X load is legal only for index 2 or 3, and a Y load only for index 4 or 5. An illegal load changes no register, and that side's error flag is high during the single cycle after the edge that sampled the request.
- R8: System-port codes are 0 = A0, 1 = X0, 2 = X1, 3 = Y0, 4 = Y1, 5 = status. The read data is bits 31..0 of the selected register. Codes 6 and 7 read zero, and writes to them change nothing.
- R9: A system write to A0 stores the 32-bit value and fills its guard bits with copies of bit 31.
- R10: When several writes target one register in the same cycle, a memory load beats a system write, and a system write beats a DSP write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rdSelA | input | 3 | Source A register index |
| rdDataA | output | 40 | Source A value, widened |
| rdSelB | input | 3 | Source B register index |
| rdDataB | output | 40 | Source B value, widened |
| dspWrEn | input | 1 | DSP result write enable |
| dspWrSel | input | 3 | DSP result register index |
| dspWrData | input | 40 | DSP result value |
| xLdEn | input | 1 | X memory load request |
| xLdSel | input | 3 | X load target index |
| xLdData | input | 16 | X load halfword |
| xLdErr | output | 1 | Illegal X load target, one-cycle pulse |
| yLdEn | input | 1 | Y memory load request |
| yLdSel | input | 3 | Y load target index |
| yLdData | input | 16 | Y load halfword |
| yLdErr | output | 1 | Illegal Y load target, one-cycle pulse |
| xStSel | input | 3 | X store source index |
| xStData | output | 16 | Bits 31..16 of the X store source |
| yStSel | input | 3 | Y store source index |
| yStData | output | 16 | Bits 31..16 of the Y store source |
| sysWrEn | input | 1 | System-register write enable |
| sysSel | input | 3 | System-register code |
| sysWrData | input | 32 | System-register write value |
| sysRdData | output | 32 | System-register read value |

## Verification
Every stored bit can be seen at a port the cycle after it is written, because the read ports are combinational. A corrupted guard field therefore shows up at once as a wrong top byte when an accumulator is read. A 32-bit register that wrongly holds guard state shows up as bits 39..32 that are not copies of bit 31. Wrong write priority, or a rejected load that still writes, leaves a wrong value that a source, store or system read exposes on the next cycle. A missing or stretched error pulse is seen on the flag itself one edge after the request.

// File: rtl/dspreg_pkg.sv
package dspreg_pkg;
  localparam int NUM_REGS = 8;
  localparam int IDX_W    = 3;
  localparam int NUM_ACC  = 2;

  localparam logic [IDX_W-1:0] IDX_X0 = 3'd2;
  localparam logic [IDX_W-1:0] IDX_X1 = 3'd3;
  localparam logic [IDX_W-1:0] IDX_Y0 = 3'd4;
  localparam logic [IDX_W-1:0] IDX_Y1 = 3'd5;

  localparam logic [IDX_W-1:0] SYS_STATUS = 3'd5;

  typedef enum logic [1:0] {
    SRC_DSP = 2'd0,
    SRC_XLD = 2'd1,
    SRC_YLD = 2'd2,
    SRC_SYS = 2'd3
  } wrSrc_e;

  typedef struct packed {
    logic   [NUM_REGS-1:0] regWe;
    wrSrc_e [NUM_REGS-1:0] regSrc;
    logic                  statusWe;
  } wrStrobes_t;
endpackage

// File: rtl/dspreg_ctrl.sv
module dspreg_ctrl
  import dspreg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             dspWrEn,
  input  logic [IDX_W-1:0] dspWrSel,
  input  logic             xLdEn,
  input  logic [IDX_W-1:0] xLdSel,
  input  logic             yLdEn,
  input  logic [IDX_W-1:0] yLdSel,
  input  logic             sysWrEn,
  input  logic [IDX_W-1:0] sysSel,
  output wrStrobes_t       strobes,
  output logic             xLdErr,
  output logic             yLdErr
);
  logic             xLegal, yLegal;
  logic             sysHitsReg;
  logic [IDX_W-1:0] sysIdx;

  assign xLegal = (xLdSel == IDX_X0) || (xLdSel == IDX_X1);
  assign yLegal = (yLdSel == IDX_Y0) || (yLdSel == IDX_Y1);

  // System code to data-register index; codes above 4 hit no data register.
  always_comb begin
    sysHitsReg = 1'b1;
    unique case (sysSel)
      3'd0:    sysIdx = 3'd0;
      3'd1:    sysIdx = IDX_X0;
      3'd2:    sysIdx = IDX_X1;
      3'd3:    sysIdx = IDX_Y0;
      3'd4:    sysIdx = IDX_Y1;
      default: begin
        sysIdx     = 3'd0;
        sysHitsReg = 1'b0;
      end
    endcase
  end

  // Later assignments override earlier ones: load > system > DSP.
  always_comb begin
    strobes = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      strobes.regSrc[i] = SRC_DSP;
      if (dspWrEn && dspWrSel == 3'(i)) begin
        strobes.regWe[i]  = 1'b1;
        strobes.regSrc[i] = SRC_DSP;
      end
      if (sysWrEn && sysHitsReg && sysIdx == 3'(i)) begin
        strobes.regWe[i]  = 1'b1;
        strobes.regSrc[i] = SRC_SYS;
      end
      if (yLdEn && yLegal && yLdSel == 3'(i)) begin
        strobes.regWe[i]  = 1'b1;
        strobes.regSrc[i] = SRC_YLD;
      end
      if (xLdEn && xLegal && xLdSel == 3'(i)) begin
        strobes.regWe[i]  = 1'b1;
        strobes.regSrc[i] = SRC_XLD;
      end
    end
    strobes.statusWe = sysWrEn && (sysSel == SYS_STATUS);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xLdErr <= 1'b0;
      yLdErr <= 1'b0;
    end else begin
      xLdErr <= xLdEn && !xLegal;
      yLdErr <= yLdEn && !yLegal;
    end
  end
endmodule

// File: rtl/dspreg_dp.sv
module dspreg_dp
  import dspreg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 8,
  parameter int MEM_W   = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wrStrobes_t                strobes,
  input  logic [IDX_W-1:0]          rdSelA,
  output logic [DATA_W+GUARD_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]          rdSelB,
  output logic [DATA_W+GUARD_W-1:0] rdDataB,
  input  logic [DATA_W+GUARD_W-1:0] dspWrData,
  input  logic [MEM_W-1:0]          xLdData,
  input  logic [MEM_W-1:0]          yLdData,
  input  logic [IDX_W-1:0]          xStSel,
  output logic [MEM_W-1:0]          xStData,
  input  logic [IDX_W-1:0]          yStSel,
  output logic [MEM_W-1:0]          yStData,
  input  logic [IDX_W-1:0]          sysSel,
  input  logic [DATA_W-1:0]         sysWrData,
  output logic [DATA_W-1:0]         sysRdData
);
  localparam int ACC_W = DATA_W + GUARD_W;
  localparam int PAD_W = DATA_W - MEM_W;

  logic [DATA_W-1:0] bodyQ [NUM_REGS];
  logic [ACC_W-1:0]  wideVal [NUM_REGS];
  logic [DATA_W-1:0] statusQ;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bodyQ[g] <= '0;
      end else if (strobes.regWe[g]) begin
        unique case (strobes.regSrc[g])
          SRC_DSP: bodyQ[g] <= dspWrData[DATA_W-1:0];
          SRC_XLD: bodyQ[g] <= {xLdData, {PAD_W{1'b0}}};
          SRC_YLD: bodyQ[g] <= {yLdData, {PAD_W{1'b0}}};
          SRC_SYS: bodyQ[g] <= sysWrData;
        endcase
      end
    end

    if (g < NUM_ACC) begin : g_acc
      logic [GUARD_W-1:0] guardQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          guardQ <= '0;
        end else if (strobes.regWe[g]) begin
          if (strobes.regSrc[g] == SRC_DSP)
            guardQ <= dspWrData[ACC_W-1:DATA_W];
          else if (strobes.regSrc[g] == SRC_SYS)
            guardQ <= {GUARD_W{sysWrData[DATA_W-1]}};
        end
      end
      assign wideVal[g] = {guardQ, bodyQ[g]};
    end else begin : g_plain
      assign wideVal[g] = {{GUARD_W{bodyQ[g][DATA_W-1]}}, bodyQ[g]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 statusQ <= '0;
    else if (strobes.statusWe) statusQ <= sysWrData;
  end

  assign rdDataA = wideVal[rdSelA];
  assign rdDataB = wideVal[rdSelB];
  assign xStData = bodyQ[xStSel][DATA_W-1 -: MEM_W];
  assign yStData = bodyQ[yStSel][DATA_W-1 -: MEM_W];

  always_comb begin
    unique case (sysSel)
      3'd0:       sysRdData = bodyQ[0];
      3'd1:       sysRdData = bodyQ[IDX_X0];
      3'd2:       sysRdData = bodyQ[IDX_X1];
      3'd3:       sysRdData = bodyQ[IDX_Y0];
      3'd4:       sysRdData = bodyQ[IDX_Y1];
      SYS_STATUS: sysRdData = statusQ;
      default:    sysRdData = '0;
    endcase
  end
endmodule

// File: rtl/dsp_guard_regfile.sv
module dsp_guard_regfile
  import dspreg_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 8,
  parameter int MEM_W   = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [2:0]                rdSelA,
  output logic [DATA_W+GUARD_W-1:0] rdDataA,
  input  logic [2:0]                rdSelB,
  output logic [DATA_W+GUARD_W-1:0] rdDataB,
  input  logic                      dspWrEn,
  input  logic [2:0]                dspWrSel,
  input  logic [DATA_W+GUARD_W-1:0] dspWrData,
  input  logic                      xLdEn,
  input  logic [2:0]                xLdSel,
  input  logic [MEM_W-1:0]          xLdData,
  output logic                      xLdErr,
  input  logic                      yLdEn,
  input  logic [2:0]                yLdSel,
  input  logic [MEM_W-1:0]          yLdData,
  output logic                      yLdErr,
  input  logic [2:0]                xStSel,
  output logic [MEM_W-1:0]          xStData,
  input  logic [2:0]                yStSel,
  output logic [MEM_W-1:0]          yStData,
  input  logic                      sysWrEn,
  input  logic [2:0]                sysSel,
  input  logic [DATA_W-1:0]         sysWrData,
  output logic [DATA_W-1:0]         sysRdData
);
  wrStrobes_t strobes;

  dspreg_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dspWrEn  (dspWrEn),
    .dspWrSel (dspWrSel),
    .xLdEn    (xLdEn),
    .xLdSel   (xLdSel),
    .yLdEn    (yLdEn),
    .yLdSel   (yLdSel),
    .sysWrEn  (sysWrEn),
    .sysSel   (sysSel),
    .strobes  (strobes),
    .xLdErr   (xLdErr),
    .yLdErr   (yLdErr)
  );

  dspreg_dp #(.DATA_W(DATA_W), .GUARD_W(GUARD_W), .MEM_W(MEM_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rdSelA    (rdSelA),
    .rdDataA   (rdDataA),
    .rdSelB    (rdSelB),
    .rdDataB   (rdDataB),
    .dspWrData (dspWrData),
    .xLdData   (xLdData),
    .yLdData   (yLdData),
    .xStSel    (xStSel),
    .xStData   (xStData),
    .yStSel    (yStSel),
    .yStData   (yStData),
    .sysSel    (sysSel),
    .sysWrData (sysWrData),
    .sysRdData (sysRdData)
  );
endmodule

// File: rtl/dspreg_chk.sv
module dspreg_chk #(
  parameter int DATA_W  = 32,
  parameter int GUARD_W = 8,
  parameter int MEM_W   = 16
) (
  input logic                      clk,
  input logic                      rstN,
  input logic [2:0]                rdSelA,
  input logic [DATA_W+GUARD_W-1:0] rdDataA,
  input logic [2:0]                rdSelB,
  input logic [DATA_W+GUARD_W-1:0] rdDataB,
  input logic                      dspWrEn,
  input logic [2:0]                dspWrSel,
  input logic                      xLdEn,
  input logic [2:0]                xLdSel,
  input logic [MEM_W-1:0]          xLdData,
  input logic                      xLdErr,
  input logic                      yLdEn,
  input logic [2:0]                yLdSel,
  input logic                      yLdErr,
  input logic [2:0]                xStSel,
  input logic [MEM_W-1:0]          xStData,
  input logic                      sysWrEn,
  input logic [2:0]                sysSel,
  input logic [DATA_W-1:0]         sysRdData
);
  localparam int ACC_W = DATA_W + GUARD_W;

  logic xBad, yBad;
  assign xBad = xLdEn && !(xLdSel == 3'd2 || xLdSel == 3'd3);
  assign yBad = yLdEn && !(yLdSel == 3'd4 || yLdSel == 3'd5);

  p_sign_ext_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdSelB >= 3'd2) |-> rdDataB[ACC_W-1:DATA_W] == {GUARD_W{rdDataB[DATA_W-1]}});

  p_guard_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdSelA == 3'd0 && !(dspWrEn && dspWrSel == 3'd0) && !(sysWrEn && sysSel == 3'd0))
    |=> (rdSelA != 3'd0) || $stable(rdDataA[ACC_W-1:DATA_W]));

  p_xload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (xLdEn && xLdSel == 3'd2) |=> (xStSel != 3'd2) || (xStData == $past(xLdData)));

  p_xerr_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    xBad |=> xLdErr);

  p_xerr_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    xLdErr |-> $past(xBad));

  p_yerr_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    yLdErr |-> $past(yBad));

  p_bad_load_no_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (xBad && !yLdEn && !dspWrEn && !sysWrEn)
    |=> (rdSelA != $past(rdSelA)) || $stable(rdDataA));

  p_sys_view_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sysSel == 3'd0 && rdSelB == 3'd0) |-> sysRdData == rdDataB[DATA_W-1:0]);
endmodule

bind dsp_guard_regfile dspreg_chk #(.DATA_W(DATA_W), .GUARD_W(GUARD_W), .MEM_W(MEM_W)) i_chk (.*);

// File: tb/test_dsp_guard_regfile.sv
module test_dsp_guard_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  rdSelA = '0, rdSelB = '0;
  logic [39:0] rdDataA, rdDataB;
  logic        dspWrEn = 1'b0;
  logic [2:0]  dspWrSel = '0;
  logic [39:0] dspWrData = '0;
  logic        xLdEn = 1'b0, yLdEn = 1'b0;
  logic [2:0]  xLdSel = '0, yLdSel = '0;
  logic [15:0] xLdData = '0, yLdData = '0;
  logic        xLdErr, yLdErr;
  logic [2:0]  xStSel = '0, yStSel = '0;
  logic [15:0] xStData, yStData;
  logic        sysWrEn = 1'b0;
  logic [2:0]  sysSel = '0;
  logic [31:0] sysWrData = '0;
  logic [31:0] sysRdData;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsp_guard_regfile i_dsp_guard_regfile (.*);

  typedef struct packed {
    logic        en;
    logic [2:0]  sel;
    logic [39:0] data;
    logic [39:0] exp;
  } vec_t;

  // DSP write then read-back on both source ports (R2..R5).
  localparam vec_t VECS [9] = '{
    '{1'b1, 3'd0, 40'h80_1234_5678, 40'h80_1234_5678},
    '{1'b1, 3'd1, 40'h7F_8000_0001, 40'h7F_8000_0001},
    '{1'b1, 3'd2, 40'hAB_8000_0000, 40'hFF_8000_0000},
    '{1'b1, 3'd3, 40'h12_0000_7FFF, 40'h00_0000_7FFF},
    '{1'b1, 3'd4, 40'h00_FFFF_0000, 40'hFF_FFFF_0000},
    '{1'b1, 3'd5, 40'hFF_1234_5678, 40'h00_1234_5678},
    '{1'b1, 3'd6, 40'h55_C000_0001, 40'hFF_C000_0001},
    '{1'b1, 3'd7, 40'h01_0000_0002, 40'h00_0000_0002},
    '{1'b0, 3'd0, 40'h33_3333_3333, 40'h80_1234_5678}
  };

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    dspWrEn = 1'b0;
    xLdEn   = 1'b0;
    yLdEn   = 1'b0;
    sysWrEn = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick();
    tick();
    rstN = 1'b1;
    tick();

    // R1: reset state
    for (int i = 0; i < 8; i++) begin
      rdSelA = 3'(i);
      #1 check("R1 reset register", rdDataA, 40'h0);
    end
    sysSel = 3'd5;
    #1 check("R1 reset status", {8'h0, sysRdData}, 40'h0);
    check("R1 reset errors", {38'h0, xLdErr, yLdErr}, 40'h0);

    // Table: R2 R3 R4 R5
    for (int v = 0; v < 9; v++) begin
      dspWrEn   = VECS[v].en;
      dspWrSel  = VECS[v].sel;
      dspWrData = VECS[v].data;
      tick();
      idle();
      rdSelA = VECS[v].sel;
      rdSelB = VECS[v].sel;
      #1;
      check("R5 R3 R4 table port A", rdDataA, VECS[v].exp);
      check("R2 table port B", rdDataB, VECS[v].exp);
    end

    // R6: legal loads on both sides in one cycle
    xLdEn = 1'b1; xLdSel = 3'd2; xLdData = 16'hBEEF;
    yLdEn = 1'b1; yLdSel = 3'd5; yLdData = 16'h1234;
    tick();
    idle();
    rdSelA = 3'd2; rdSelB = 3'd5; xStSel = 3'd2; yStSel = 3'd5;
    #1;
    check("R6 X0 after load", rdDataA, 40'hFF_BEEF_0000);
    check("R6 Y1 after load", rdDataB, 40'h00_1234_0000);
    check("R6 X store data", {24'h0, xStData}, 40'h0_BEEF);
    check("R6 Y store data", {24'h0, yStData}, 40'h0_1234);
    check("R7 no error on legal load", {38'h0, xLdErr, yLdErr}, 40'h0);

    // R7: illegal X load into Y0
    xLdEn = 1'b1; xLdSel = 3'd4; xLdData = 16'h5555;
    tick();
    idle();
    rdSelA = 3'd4;
    #1;
    check("R7 X error pulse", {39'h0, xLdErr}, 40'h1);
    check("R7 Y0 unchanged", rdDataA, 40'hFF_FFFF_0000);
    tick();
    check("R7 X error one cycle", {39'h0, xLdErr}, 40'h0);

    // R7: illegal Y load into A0
    yLdEn = 1'b1; yLdSel = 3'd0; yLdData = 16'h6666;
    tick();
    idle();
    rdSelA = 3'd0;
    #1;
    check("R7 Y error pulse", {39'h0, yLdErr}, 40'h1);
    check("R7 A0 unchanged", rdDataA, 40'h80_1234_5678);
    tick();
    check("R7 Y error one cycle", {39'h0, yLdErr}, 40'h0);

    // R8: system reads
    sysSel = 3'd0;
    #1 check("R8 sys read A0 low", {8'h0, sysRdData}, 40'h00_1234_5678);
    sysSel = 3'd2;
    #1 check("R8 sys read X1", {8'h0, sysRdData}, 40'h00_0000_7FFF);
    sysSel = 3'd4;
    #1 check("R8 sys read Y1", {8'h0, sysRdData}, 40'h00_1234_0000);

    // R9: system write to A0 sign-extends into guard
    sysWrEn = 1'b1; sysSel = 3'd0; sysWrData = 32'h9000_0001;
    tick();
    idle();
    rdSelA = 3'd0; xStSel = 3'd0;
    #1;
    check("R9 A0 guard from sys write", rdDataA, 40'hFF_9000_0001);
    check("R6 store from accumulator", {24'h0, xStData}, 40'h0_9000);

    // R8: status write, then undefined code ignored
    sysWrEn = 1'b1; sysSel = 3'd5; sysWrData = 32'hCAFE_F00D;
    tick();
    idle();
    #1 check("R8 status readback", {8'h0, sysRdData}, 40'h00_CAFE_F00D);
    sysWrEn = 1'b1; sysSel = 3'd6; sysWrData = 32'hDEAD_BEEF;
    tick();
    idle();
    #1 check("R8 code 6 reads zero", {8'h0, sysRdData}, 40'h0);
    sysSel = 3'd7;
    #1 check("R8 code 7 reads zero", {8'h0, sysRdData}, 40'h0);
    sysSel = 3'd5;
    #1 check("R8 status kept", {8'h0, sysRdData}, 40'h00_CAFE_F00D);
    rdSelA = 3'd0;
    #1 check("R8 A0 kept", rdDataA, 40'hFF_9000_0001);

    // R10: load beats DSP write
    dspWrEn = 1'b1; dspWrSel = 3'd2; dspWrData = 40'h00_1111_1111;
    xLdEn = 1'b1; xLdSel = 3'd2; xLdData = 16'h00AA;
    tick();
    idle();
    rdSelA = 3'd2;
    #1 check("R10 load over DSP", rdDataA, 40'h00_00AA_0000);

    // R10: system write beats DSP write
    dspWrEn = 1'b1; dspWrSel = 3'd3; dspWrData = 40'h00_3333_3333;
    sysWrEn = 1'b1; sysSel = 3'd2; sysWrData = 32'h2222_2222;
    tick();
    idle();
    rdSelA = 3'd3;
    #1 check("R10 sys over DSP", rdDataA, 40'h00_2222_2222);

    // R10: load beats system write
    xLdEn = 1'b1; xLdSel = 3'd3; xLdData = 16'h0077;
    sysWrEn = 1'b1; sysSel = 3'd2; sysWrData = 32'h4444_4444;
    tick();
    idle();
    #1 check("R10 load over sys", rdDataA, 40'h00_0077_0000);

    // R10 with R9: system write beats DSP write on an accumulator
    dspWrEn = 1'b1; dspWrSel = 3'd0; dspWrData = 40'h7F_0000_0000;
    sysWrEn = 1'b1; sysSel = 3'd0; sysWrData = 32'h0000_0005;
    tick();
    idle();
    rdSelA = 3'd0;
    #1 check("R10 sys over DSP on A0", rdDataA, 40'h00_0000_0005);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule